// File: doc/BRIEF.md
# Diagnostic Configure Command Handler

This block sits behind the command decoder of a secondary station on a synchronous serial link. It takes decoded command frames of two kinds, configure and test, whose payload arrives as a byte stream with valid and last markers after a start strobe. A configure frame carries one payload byte that sets or clears sticky diagnostic modes. A test frame is answered with a response byte stream to the frame transmitter. The shape of that response depends on the current modes.

Three diagnostic modes exist. Silent mode keeps the station from generating responses, but it does not touch the line itself. Local loopback routes the received line bit straight to the transmitted line bit. Replicate mode makes a test response out of copies of the first test byte instead of an echo of the whole payload. A configure frame is always answered with an echo of its payload byte, unless silence forbids it. Bit-level framing, bit stuffing and frame check sequences are handled elsewhere.

Top module: `diag_cfg_handler`

## Requirements
- R1: After reset all three modes are clear, tx_valid is low and line_tx_bit follows framer_tx_bit.
- R2: A configure frame of exactly one byte is answered with a one-byte response equal to that byte, with tx_last set on it.
- R3: A configure byte of 0x00 clears silent, loopback and replicate together.
- R4: A nonzero configure byte ORs its bits into the modes: bit 0 sets silent, bit 1 sets loopback and bit 2 sets replicate. Set modes stay set, and bits 7 to 3 have no effect.
- R5: A configure frame whose payload is not exactly one byte produces no response and leaves every mode unchanged.
- R6: Outside replicate mode, a test frame of N bytes is answered with its first min(N,16) bytes in order. tx_last is set on the final byte.
- R7: In replicate mode, a test frame of N bytes is answered with min(N,16) copies of its first byte.
- R8: While silent is set, no test response and no configure response is sent. The one exception is a configure byte of 0x00, whose echo is still sent. A configure frame that sets silent while silent is clear is still echoed.
- R9: With loopback set, line_tx_bit equals line_rx_bit. With loopback clear, line_tx_bit equals framer_tx_bit.
- R10: A response's first byte appears on tx_valid two clock edges after the edge that takes the last payload byte, and its bytes follow on consecutive cycles. A mode change takes effect on that same second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Opens a command frame; honoured only when idle |
| cmd_is_test | input | 1 | Frame kind at cmd_start: 1 test, 0 configure |
| rx_valid | input | 1 | Payload byte valid, from the cycle after cmd_start |
| rx_data | input | 8 | Payload byte |
| rx_last | input | 1 | Marks the final payload byte |
| line_rx_bit | input | 1 | Serial bit received from the line |
| framer_tx_bit | input | 1 | Serial bit from the station's frame transmitter |
| line_tx_bit | output | 1 | Serial bit driven onto the line |
| mode_silent | output | 1 | Silent mode flag |
| mode_loopback | output | 1 | Local loopback flag |
| mode_replicate | output | 1 | Test-replicate flag |
| tx_valid | output | 1 | Response byte valid |
| tx_data | output | 8 | Response byte |
| tx_last | output | 1 | Final response byte |

## Verification
Embedded properties check these rules on every cycle: a zero configure byte empties the modes on the next edge, nonzero bytes never drop a mode, a malformed configure frame changes no mode, a silent station answers no test frame, a replicated response holds one byte value, and tx_valid drops after tx_last. Only the bench's scenarios can show the exact contents and lengths of responses, including the truncation at 16 bytes, the echo rule at the moment silence is set or cleared, the ignored upper payload bits, the two-edge latency and the line path in loopback.

// File: rtl/diag_cfg_pkg.sv
package diag_cfg_pkg;

   typedef enum logic {
      CMD_CFG  = 1'b0,
      CMD_TEST = 1'b1
   } cmd_kind_e;

   typedef struct packed {
      logic replicate;
      logic loopback;
      logic silent;
   } diag_mode_t;

endpackage

// File: rtl/diag_rx_capture.sv
module diag_rx_capture
   import diag_cfg_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         open_i,
   input  logic                         is_test_i,
   input  logic                         rx_valid_i,
   input  logic [DATA_W-1:0]            rx_data_i,
   input  logic                         rx_last_i,
   output logic                         active_o,
   output logic                         done_o,
   output cmd_kind_e                    kind_o,
   output logic [CNT_W-1:0]             len_o,
   output logic [DEPTH-1:0][DATA_W-1:0] buf_o
);

   logic             active_q;
   logic             done_q;
   cmd_kind_e        kind_q;
   logic [CNT_W-1:0] cnt_q;
   logic             take;
   logic             room;

   assign take = active_q & rx_valid_i;
   assign room = cnt_q < CNT_W'(DEPTH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         done_q   <= 1'b0;
         kind_q   <= CMD_CFG;
         cnt_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (open_i) begin
            active_q <= 1'b1;
            kind_q   <= is_test_i ? CMD_TEST : CMD_CFG;
            cnt_q    <= '0;
         end else if (take) begin
            if (room) cnt_q <= cnt_q + CNT_W'(1);
            if (rx_last_i) begin
               active_q <= 1'b0;
               done_q   <= 1'b1;
            end
         end
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n) slot_q <= '0;
         else if (take && cnt_q == CNT_W'(i)) slot_q <= rx_data_i;
      end
      assign buf_o[i] = slot_q;
   end

   assign active_o = active_q;
   assign done_o   = done_q;
   assign kind_o   = kind_q;
   assign len_o    = cnt_q;

   // R6: the stored length never passes the buffer depth
   a_r6_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/diag_mode_regs.sv
module diag_mode_regs
   import diag_cfg_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 5,
   parameter int SIL_BIT  = 0,
   parameter int LOOP_BIT = 1,
   parameter int REP_BIT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  cmd_kind_e         kind_i,
   input  logic [CNT_W-1:0]  len_i,
   input  logic [DATA_W-1:0] first_i,
   output diag_mode_t        mode_o,
   output logic              echo_o
);

   diag_mode_t mode_q;
   diag_mode_t req;
   logic       cfg_ok;
   logic       clear;

   assign cfg_ok = done_i && (kind_i == CMD_CFG) && (len_i == CNT_W'(1));
   assign clear  = (first_i == '0);

   always_comb begin
      req.silent    = first_i[SIL_BIT];
      req.loopback  = first_i[LOOP_BIT];
      req.replicate = first_i[REP_BIT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (cfg_ok) begin
         mode_q <= clear ? diag_mode_t'('0) : (mode_q | req);
      end
   end

   assign echo_o = cfg_ok && (!mode_q.silent || clear);
   assign mode_o = mode_q;

   // R3: a zero byte empties every mode
   a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ok && clear) |=> (mode_q == '0));

   // R4: nonzero bytes only add modes
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ok && !clear) |=> ((mode_q & $past(mode_q)) == $past(mode_q)));

   // R5: malformed configure frames leave modes alone
   a_r5_bad_len_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && kind_i == CMD_CFG && len_i != CNT_W'(1)) |=> $stable(mode_q));

endmodule

// File: rtl/diag_resp_gen.sv
module diag_resp_gen #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = $clog2(DEPTH + 1),
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fire_i,
   input  logic [CNT_W-1:0]             len_i,
   input  logic                         repl_i,
   input  logic [DEPTH-1:0][DATA_W-1:0] buf_i,
   output logic                         busy_o,
   output logic                         tx_valid_o,
   output logic [DATA_W-1:0]            tx_data_o,
   output logic                         tx_last_o
);

   logic             busy_q;
   logic             repl_q;
   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] end_q;
   logic [IDX_W-1:0] rd_idx;
   logic             at_end;

   assign at_end = (ptr_q == end_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         repl_q <= 1'b0;
         ptr_q  <= '0;
         end_q  <= '0;
      end else if (!busy_q) begin
         if (fire_i) begin
            busy_q <= 1'b1;
            repl_q <= repl_i;
            ptr_q  <= '0;
            end_q  <= IDX_W'(len_i - CNT_W'(1));
         end
      end else if (at_end) begin
         busy_q <= 1'b0;
      end else begin
         ptr_q <= ptr_q + IDX_W'(1);
      end
   end

   assign rd_idx     = repl_q ? '0 : ptr_q;
   assign tx_valid_o = busy_q;
   assign tx_data_o  = busy_q ? buf_i[rd_idx] : '0;
   assign tx_last_o  = busy_q && at_end;
   assign busy_o     = busy_q;

   // R10: exactly one last marker closes each response
   a_r10_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last_o |=> !tx_valid_o);

   // R7: a replicated response carries one byte value throughout
   a_r7_repl_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && repl_q && $past(tx_valid_o)) |-> $stable(tx_data_o));

endmodule

// File: rtl/diag_cfg_handler.sv
module diag_cfg_handler
   import diag_cfg_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int BUF_DEPTH   = 16,
   parameter int SILENT_BIT  = 0,
   parameter int LOOP_BIT    = 1,
   parameter int REPL_BIT    = 2,
   parameter bit LOOP_RETIME = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_is_test,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_last,
   input  logic              line_rx_bit,
   input  logic              framer_tx_bit,
   output logic              line_tx_bit,
   output logic              mode_silent,
   output logic              mode_loopback,
   output logic              mode_replicate,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_last
);

   localparam int CNT_W = $clog2(BUF_DEPTH + 1);
   localparam int IDX_W = $clog2(BUF_DEPTH);

   if (BUF_DEPTH < 2) begin : g_bad_depth
      $error("BUF_DEPTH must be at least 2");
   end
   if (SILENT_BIT >= DATA_W || LOOP_BIT >= DATA_W || REPL_BIT >= DATA_W) begin : g_bad_bits
      $error("mode bit positions must lie inside the payload byte");
   end

   logic                            cap_active;
   logic                            cap_done;
   cmd_kind_e                       cap_kind;
   logic [CNT_W-1:0]                cap_len;
   logic [BUF_DEPTH-1:0][DATA_W-1:0] cap_buf;
   diag_mode_t                      mode;
   logic                            cfg_echo;
   logic                            resp_busy;
   logic                            open;
   logic                            fire;
   logic                            is_test_done;
   logic [CNT_W-1:0]                fire_len;
   logic                            fire_repl;

   assign open = cmd_start & ~cap_active & ~cap_done & ~resp_busy;

   diag_rx_capture #(
      .DATA_W (DATA_W),
      .DEPTH  (BUF_DEPTH),
      .CNT_W  (CNT_W)
   ) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_i     (open),
      .is_test_i  (cmd_is_test),
      .rx_valid_i (rx_valid),
      .rx_data_i  (rx_data),
      .rx_last_i  (rx_last),
      .active_o   (cap_active),
      .done_o     (cap_done),
      .kind_o     (cap_kind),
      .len_o      (cap_len),
      .buf_o      (cap_buf)
   );

   diag_mode_regs #(
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W),
      .SIL_BIT  (SILENT_BIT),
      .LOOP_BIT (LOOP_BIT),
      .REP_BIT  (REPL_BIT)
   ) u_modes (
      .clk     (clk),
      .rst_n   (rst_n),
      .done_i  (cap_done),
      .kind_i  (cap_kind),
      .len_i   (cap_len),
      .first_i (cap_buf[0]),
      .mode_o  (mode),
      .echo_o  (cfg_echo)
   );

   assign is_test_done = cap_done && (cap_kind == CMD_TEST);
   assign fire         = cfg_echo | (is_test_done & ~mode.silent);
   assign fire_len     = is_test_done ? cap_len : CNT_W'(1);
   assign fire_repl    = is_test_done & mode.replicate;

   diag_resp_gen #(
      .DATA_W (DATA_W),
      .DEPTH  (BUF_DEPTH),
      .CNT_W  (CNT_W),
      .IDX_W  (IDX_W)
   ) u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (fire),
      .len_i      (fire_len),
      .repl_i     (fire_repl),
      .buf_i      (cap_buf),
      .busy_o     (resp_busy),
      .tx_valid_o (tx_valid),
      .tx_data_o  (tx_data),
      .tx_last_o  (tx_last)
   );

   if (LOOP_RETIME) begin : g_line_reg
      logic line_q;
      always_ff @(posedge clk) begin
         if (!rst_n) line_q <= 1'b0;
         else        line_q <= mode.loopback ? line_rx_bit : framer_tx_bit;
      end
      assign line_tx_bit = line_q;
   end else begin : g_line_comb
      assign line_tx_bit = mode.loopback ? line_rx_bit : framer_tx_bit;
   end

   assign mode_silent    = mode.silent;
   assign mode_loopback  = mode.loopback;
   assign mode_replicate = mode.replicate;

   // R8: a silent station answers no test frame
   a_r8_silent_test_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (is_test_done && mode_silent) |=> !tx_valid);

   // R2: a configure echo is a single byte
   a_r2_echo_single: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_done && cap_kind == CMD_CFG && cfg_echo) |=> (tx_valid && tx_last));

endmodule

// File: tb/diag_cfg_handler_bench.sv
`timescale 1ns/1ps
module diag_cfg_handler_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_start = 1'b0;
   logic       cmd_is_test = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_last = 1'b0;
   logic       line_rx_bit = 1'b0;
   logic       framer_tx_bit = 1'b0;
   logic       line_tx_bit;
   logic       mode_silent, mode_loopback, mode_replicate;
   logic       tx_valid;
   logic [7:0] tx_data;
   logic       tx_last;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   diag_cfg_handler u_diag_cfg_handler (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_start      (cmd_start),
      .cmd_is_test    (cmd_is_test),
      .rx_valid       (rx_valid),
      .rx_data        (rx_data),
      .rx_last        (rx_last),
      .line_rx_bit    (line_rx_bit),
      .framer_tx_bit  (framer_tx_bit),
      .line_tx_bit    (line_tx_bit),
      .mode_silent    (mode_silent),
      .mode_loopback  (mode_loopback),
      .mode_replicate (mode_replicate),
      .tx_valid       (tx_valid),
      .tx_data        (tx_data),
      .tx_last        (tx_last)
   );

   // {is_test, len[4:0], seed[7:0], modes {repl,loop,silent}, resp_len[4:0], replicated}
   localparam int NVEC = 15;
   localparam logic [22:0] VEC [NVEC] = '{
      {1'b0, 5'd1,  8'h00, 3'b000, 5'd1,  1'b0},  // R2 R3
      {1'b1, 5'd4,  8'h10, 3'b000, 5'd4,  1'b0},  // R6
      {1'b0, 5'd1,  8'h04, 3'b100, 5'd1,  1'b0},  // R4
      {1'b1, 5'd5,  8'h30, 3'b100, 5'd5,  1'b1},  // R7
      {1'b0, 5'd1,  8'hFA, 3'b110, 5'd1,  1'b0},  // R4 upper bits ignored
      {1'b0, 5'd2,  8'h01, 3'b110, 5'd0,  1'b0},  // R5
      {1'b0, 5'd1,  8'h00, 3'b000, 5'd1,  1'b0},  // R3
      {1'b1, 5'd16, 8'h40, 3'b000, 5'd16, 1'b0},  // R6 full buffer
      {1'b1, 5'd20, 8'h50, 3'b000, 5'd16, 1'b0},  // R6 truncation
      {1'b0, 5'd1,  8'h01, 3'b001, 5'd1,  1'b0},  // R8 setting silent is echoed
      {1'b1, 5'd3,  8'h60, 3'b001, 5'd0,  1'b0},  // R8 silent test
      {1'b0, 5'd1,  8'h02, 3'b011, 5'd0,  1'b0},  // R8 silent configure
      {1'b0, 5'd1,  8'h00, 3'b000, 5'd1,  1'b0},  // R8 clearing echo
      {1'b0, 5'd1,  8'h04, 3'b100, 5'd1,  1'b0},  // R4
      {1'b1, 5'd20, 8'h70, 3'b100, 5'd16, 1'b1}   // R7 truncation
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input logic is_test, input int n, input logic [7:0] seed);
      @(negedge clk);
      cmd_start   = 1'b1;
      cmd_is_test = is_test;
      @(negedge clk);
      cmd_start = 1'b0;
      for (int i = 0; i < n; i++) begin
         rx_valid = 1'b1;
         rx_data  = seed + 8'(i);
         rx_last  = (i == n - 1);
         @(negedge clk);
      end
      rx_valid = 1'b0;
      rx_last  = 1'b0;
   endtask

   // called at the negedge right after the edge that took the last byte
   task automatic collect(input int rlen, input logic rep, input logic [7:0] seed, input string req);
      int got = 0;
      int first_at = -1;
      check(!tx_valid, "R10 quiet one edge after last byte", int'(tx_valid), 0);
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         if (tx_valid) begin
            logic [7:0] exp_b;
            if (first_at < 0) first_at = k;
            exp_b = rep ? seed : seed + 8'(got);
            check(tx_data == exp_b, req, tx_data, exp_b);
            check(tx_last == (got == rlen - 1), "R6 R7 last marker", int'(tx_last), int'(got == rlen - 1));
            got++;
         end
      end
      check(got == rlen, {req, " response length"}, got, rlen);
      if (rlen > 0) begin
         check(first_at == 1, "R10 first byte two edges after last", first_at, 1);
         check(first_at + rlen - 1 == 1 + got - 1, "R10 consecutive bytes", got, rlen);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R10: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check({mode_replicate, mode_loopback, mode_silent} == 3'b000, "R1 modes after reset",
            {mode_replicate, mode_loopback, mode_silent}, 0);
      check(!tx_valid, "R1 tx_valid after reset", int'(tx_valid), 0);
      framer_tx_bit = 1'b1; line_rx_bit = 1'b0; #1;
      check(line_tx_bit == 1'b1, "R1 line follows framer", int'(line_tx_bit), 1);

      for (int v = 0; v < NVEC; v++) begin
         logic [22:0] e;
         e = VEC[v];
         send(e[22], int'(e[21:17]), e[16:9]);
         collect(int'(e[5:1]), e[0], e[16:9], $sformatf("R2 R6 R7 R8 vector %0d data", v));
         check({mode_replicate, mode_loopback, mode_silent} == e[8:6],
               $sformatf("R3 R4 R5 vector %0d modes", v),
               {mode_replicate, mode_loopback, mode_silent}, e[8:6]);
      end

      // R10 modes change on the same edge as the first response byte
      send(1'b0, 1, 8'h00);
      collect(1, 1'b0, 8'h00, "R3 clear before loopback");
      @(negedge clk);
      cmd_start = 1'b1; cmd_is_test = 1'b0;
      @(negedge clk);
      cmd_start = 1'b0; rx_valid = 1'b1; rx_data = 8'h02; rx_last = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
      check(!mode_loopback, "R10 mode not yet applied", int'(mode_loopback), 0);
      @(negedge clk);
      check(mode_loopback && tx_valid, "R10 mode applied with first byte",
            int'({mode_loopback, tx_valid}), 3);

      // R9 loopback line path
      repeat (3) @(negedge clk);
      line_rx_bit = 1'b1; framer_tx_bit = 1'b0; #1;
      check(line_tx_bit == 1'b1, "R9 loopback follows line rx", int'(line_tx_bit), 1);
      line_rx_bit = 1'b0; framer_tx_bit = 1'b1; #1;
      check(line_tx_bit == 1'b0, "R9 loopback ignores framer", int'(line_tx_bit), 0);
      send(1'b0, 1, 8'h00);
      collect(1, 1'b0, 8'h00, "R3 clear loopback");
      #1;
      check(line_tx_bit == 1'b1, "R9 framer path restored", int'(line_tx_bit), 1);

      // R1 reset clears set modes
      send(1'b0, 1, 8'h07);
      collect(1, 1'b0, 8'h07, "R4 all modes");
      check({mode_replicate, mode_loopback, mode_silent} == 3'b111, "R4 all three set",
            {mode_replicate, mode_loopback, mode_silent}, 7);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check({mode_replicate, mode_loopback, mode_silent} == 3'b000, "R1 reset clears modes",
            {mode_replicate, mode_loopback, mode_silent}, 0);
      rst_n = 1'b1;

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule